// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block decides which of up to eight maskable interrupt sources is taken next when interrupt routines may nest. Every source carries a 3-bit urgency level, where 0 is the most urgent and 7 the least. The arbiter holds the level of the routine now running, called the running level. It takes a new request only when that request is more urgent than the running level, so a routine can be interrupted by more urgent work and never by work that is less urgent or equally urgent.

When a request is taken, the arbiter records the suspended running level as one bit in an 8-bit save register, with the bit index equal to the level. It then loads the running level with the level of the new request and clears the global enable. When an interrupt-return strobe arrives, the arbiter restores the most urgent suspended level, which is the lowest-index set bit, and clears that bit. A held-off request that beats the restored level is therefore taken before the interrupted work resumes.

The controller has two states. `ST_MAIN` means no routine is active: the save register is empty and the running level is 7. `ST_SERVICE` means at least one routine is active. Three transitions connect them. `ACCEPT` takes a request and moves to or stays in `ST_SERVICE`. `RETURN_NESTED` restores a level below 7 and stays in `ST_SERVICE`. `RETURN_LAST` restores level 7 and goes back to `ST_MAIN`.

Top module: `nest_prio_arb`

## Requirements
- R1: A synchronous active-high `rst` sets the running level to 7, clears the save register and the global enable, and keeps `ack` low.
- R2: A source can be taken only when all of the following hold: the global enable is 1, its pending line is 1, its per-source enable is 1, and its level is strictly below the running level. A request at a level equal to the running level waits.
- R3: Among the sources that can be taken, the one with the lowest level wins. When levels tie, the lowest source index wins.
- R4: Taking a request raises `ack` for exactly one cycle, in the cycle after the clock edge that took it. `ack_idx` gives the index of the winning source during that cycle.
- R5: On taking a request, bit N of `nest_lvls` is set, where N is the running level before the take. The running level then becomes the level of the winning request.
- R6: Taking a request clears the global enable. A `gie_set` pulse sets the global enable at any edge that does not take a request.
- R7: On `iret`, the running level is loaded from the index of the lowest set bit of `nest_lvls`, and that bit is cleared. If `nest_lvls` is empty, the running level becomes 7.
- R8: When `iret` and a request that could be taken are present in the same cycle, only the return is performed and no request is taken at that edge.
- R9: After a return, a pending request whose level is below the restored level is taken at the next edge, provided the global enable is 1.
- R10: The running level is 7 exactly when `nest_lvls` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | 8 | Pending request line for each source |
| irq_en | input | 8 | Enable for each source |
| src_lvl | input | 24 | Level of source i in bits [3i+2:3i] |
| gie_set | input | 1 | Sets the global enable |
| iret | input | 1 | Interrupt-return strobe |
| ack | output | 1 | One-cycle acknowledge pulse |
| ack_idx | output | 3 | Index of the acknowledged source |
| cur_lvl | output | 3 | Running priority level |
| gie | output | 1 | Global enable state |
| nest_lvls | output | 8 | Save register; bit k set means level k is suspended |

## Verification
The directed patterns cover the following cases, and each one tells apart a specific pair of behaviours:
- A pending request with the global enable off, which separates the enable gate from level comparison.
- A request masked by its per-source enable.
- A request whose level equals the running level, which separates strict comparison from less-or-equal.
- Two sources at the same level, which exposes the index tie-break.
- A lower-index source set against a more urgent higher-index one, which shows that level wins over index.

Returns are applied from two nested routines, from the last routine, and with an empty save register. A return that arrives together with an eligible request shows that the return takes precedence. A long random phase of requests, masks, levels, enables and returns is then compared on every clock against a behavioural model.

// File: rtl/nia_pkg.sv
package nia_pkg;

    typedef enum logic [0:0] {
        ST_MAIN    = 1'b0,
        ST_SERVICE = 1'b1
    } arb_state_t;

endpackage

// File: rtl/nia_pick.sv
module nia_pick #(
    parameter int N_SRC = 8,
    parameter int LVL_W = 3,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]       pend,
    input  logic [N_SRC-1:0]       en,
    input  logic [N_SRC*LVL_W-1:0] lvl_flat,
    input  logic [LVL_W-1:0]       run_lvl,
    output logic                   hit,
    output logic [IDX_W-1:0]       win_idx,
    output logic [LVL_W-1:0]       win_lvl
);

    logic [LVL_W-1:0] lvls [N_SRC];
    logic [N_SRC-1:0] elig;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign lvls[g] = lvl_flat[g*LVL_W +: LVL_W];
        assign elig[g] = pend[g] & en[g] & (lvls[g] < run_lvl);
    end

    // Scan from the top index down so that a tie leaves the lowest index.
    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        win_lvl = '1;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i] && (!hit || lvls[i] <= win_lvl)) begin
                hit     = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = lvls[i];
            end
        end
    end

endmodule

// File: rtl/nia_save.sv
module nia_save #(
    parameter int LVL_W = 3,
    localparam int NLEV = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic [NLEV-1:0]  held,
    output logic [LVL_W-1:0] rest_lvl
);

    logic [NLEV-1:0] held_q;

    // Most urgent suspended level = lowest set bit; idle level when empty.
    always_comb begin
        rest_lvl = '1;
        for (int i = NLEV - 1; i >= 0; i--) begin
            if (held_q[i]) rest_lvl = LVL_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (pop) begin
            held_q <= held_q & ~(NLEV'(1) << rest_lvl);
        end else if (push) begin
            held_q <= held_q | (NLEV'(1) << push_lvl);
        end
    end

    assign held = held_q;

endmodule

// File: rtl/nest_prio_arb.sv
module nest_prio_arb #(
    parameter int N_SRC = 8,
    parameter int LVL_W = 3,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int NLEV = 1 << LVL_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_SRC-1:0]       irq_pend,
    input  logic [N_SRC-1:0]       irq_en,
    input  logic [N_SRC*LVL_W-1:0] src_lvl,
    input  logic                   gie_set,
    input  logic                   iret,
    output logic                   ack,
    output logic [IDX_W-1:0]       ack_idx,
    output logic [LVL_W-1:0]       cur_lvl,
    output logic                   gie,
    output logic [NLEV-1:0]        nest_lvls
);
    import nia_pkg::*;

    localparam logic [LVL_W-1:0] IDLE_LVL = '1;

    arb_state_t       state_q, state_d;
    logic [LVL_W-1:0] run_lvl_q;
    logic             gie_q;
    logic             ack_q;
    logic [IDX_W-1:0] ack_idx_q;

    logic             hit;
    logic [IDX_W-1:0] win_idx;
    logic [LVL_W-1:0] win_lvl;
    logic [LVL_W-1:0] rest_lvl;
    logic             take;

    nia_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_pick (
        .pend    (irq_pend),
        .en      (irq_en),
        .lvl_flat(src_lvl),
        .run_lvl (run_lvl_q),
        .hit     (hit),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    // Return has precedence over accepting a new request.
    assign take = gie_q && hit && !iret;

    nia_save #(.LVL_W(LVL_W)) u_save (
        .clk     (clk),
        .rst     (rst),
        .push    (take),
        .push_lvl(run_lvl_q),
        .pop     (iret),
        .held    (nest_lvls),
        .rest_lvl(rest_lvl)
    );

    // Transitions: ACCEPT, RETURN_NESTED, RETURN_LAST.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MAIN: begin
                if (take) state_d = ST_SERVICE;
            end
            ST_SERVICE: begin
                if (iret && rest_lvl == IDLE_LVL) state_d = ST_MAIN;
            end
            default: state_d = ST_MAIN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_MAIN;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_lvl_q <= IDLE_LVL;
            gie_q     <= 1'b0;
            ack_q     <= 1'b0;
            ack_idx_q <= '0;
        end else begin
            ack_q <= take;
            if (take) ack_idx_q <= win_idx;
            if (iret) begin
                run_lvl_q <= (state_q == ST_MAIN) ? IDLE_LVL : rest_lvl;
            end else if (take) begin
                run_lvl_q <= win_lvl;
            end
            if (take)         gie_q <= 1'b0;
            else if (gie_set) gie_q <= 1'b1;
        end
    end

    assign ack     = ack_q;
    assign ack_idx = ack_idx_q;
    assign cur_lvl = run_lvl_q;
    assign gie     = gie_q;

endmodule

// File: rtl/nest_prio_arb_chk.sv
module nest_prio_arb_chk #(
    parameter int LVL_W = 3,
    localparam int NLEV = 1 << LVL_W
) (
    input logic             clk,
    input logic             rst,
    input logic             iret,
    input logic             ack,
    input logic             gie,
    input logic [LVL_W-1:0] cur_lvl,
    input logic [NLEV-1:0]  nest_lvls
);

    logic [LVL_W-1:0] prev_lvl;
    always_ff @(posedge clk) prev_lvl <= cur_lvl;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (cur_lvl == '1 && nest_lvls == '0 && !gie && !ack));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    a_r6_enable_cleared: assert property (@(posedge clk) disable iff (rst)
        ack |-> !gie);

    a_r2_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (!gie && !ack) |=> !ack);

    a_r5_saved_bit: assert property (@(posedge clk) disable iff (rst)
        ack |-> (nest_lvls[prev_lvl] && cur_lvl < prev_lvl));

    a_r8_return_first: assert property (@(posedge clk) disable iff (rst)
        iret |=> !ack);

    a_r7_empty_return: assert property (@(posedge clk) disable iff (rst)
        (iret && nest_lvls == '0) |=> (cur_lvl == '1 && nest_lvls == '0));

    a_r10_idle_match: assert property (@(posedge clk) disable iff (rst)
        (cur_lvl == '1) == (nest_lvls == '0));

endmodule

bind nest_prio_arb nest_prio_arb_chk #(.LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .iret     (iret),
    .ack      (ack),
    .gie      (gie),
    .cur_lvl  (cur_lvl),
    .nest_lvls(nest_lvls)
);

// File: tb/nest_prio_arb_test.sv
module nest_prio_arb_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  irq_pend, irq_en;
    logic [23:0] src_lvl;
    logic        gie_set, iret;
    logic        ack, gie;
    logic [2:0]  ack_idx, cur_lvl;
    logic [7:0]  nest_lvls;
    logic [2:0]  lv [8];

    int errs = 0, checks = 0, cycles = 0;
    bit started = 0;

    always #4 clk = ~clk;

    always_comb for (int i = 0; i < 8; i++) src_lvl[i*3 +: 3] = lv[i];

    nest_prio_arb uut (
        .clk(clk), .rst(rst), .irq_pend(irq_pend), .irq_en(irq_en),
        .src_lvl(src_lvl), .gie_set(gie_set), .iret(iret), .ack(ack),
        .ack_idx(ack_idx), .cur_lvl(cur_lvl), .gie(gie), .nest_lvls(nest_lvls)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated at every rising edge.
    int m_cpl, m_gie, m_ack, m_id;
    bit [7:0] m_nest;

    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (rst) begin
            m_cpl = 7; m_nest = 0; m_gie = 0; m_ack = 0;
        end else begin
            int best;
            m_ack = 0;
            if (iret) begin
                if (m_nest == 0) m_cpl = 7;
                else begin
                    for (int k = 7; k >= 0; k--) if (m_nest[k]) m_cpl = k;
                    m_nest[m_cpl] = 1'b0;
                end
                if (gie_set) m_gie = 1;
            end else begin
                best = -1;
                for (int i = 0; i < 8; i++)
                    if (irq_pend[i] && irq_en[i] && int'(lv[i]) < m_cpl &&
                        (best < 0 || int'(lv[i]) < int'(lv[best]))) best = i;
                if (m_gie == 1 && best >= 0) begin
                    m_nest[m_cpl] = 1'b1;
                    m_cpl = int'(lv[best]);
                    m_gie = 0; m_ack = 1; m_id = best;
                end else if (gie_set) m_gie = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            check("R4 model ack", int'(ack), m_ack);
            if (m_ack == 1) check("R3 model ack_idx", int'(ack_idx), m_id);
            check("R5 model level", int'(cur_lvl), m_cpl);
            check("R7 model save reg", int'(nest_lvls), int'(m_nest));
            check("R6 model enable", int'(gie), m_gie);
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        lv[0] = 5; lv[1] = 2; lv[2] = 2; lv[3] = 6;
        lv[4] = 0; lv[5] = 3; lv[6] = 7; lv[7] = 4;
        rst = 1; irq_pend = 0; irq_en = 8'hFF; gie_set = 0; iret = 0;
        repeat (3) tick();
        check("R1 level", int'(cur_lvl), 7);
        check("R1 save reg", int'(nest_lvls), 0);
        check("R1 enable", int'(gie), 0);
        check("R1 ack", int'(ack), 0);
        rst = 0;

        irq_pend = 8'h08;
        tick(); tick();
        check("R2 enable off ack", int'(ack), 0);
        check("R2 enable off level", int'(cur_lvl), 7);
        gie_set = 1; tick(); gie_set = 0;
        check("R6 set", int'(gie), 1);
        check("R2 set edge no take", int'(ack), 0);
        tick();
        check("R4 ack", int'(ack), 1);
        check("R4 idx", int'(ack_idx), 3);
        check("R5 level", int'(cur_lvl), 6);
        check("R5 save bit", int'(nest_lvls), 8'h80);
        check("R6 cleared", int'(gie), 0);
        irq_pend = 0; tick();
        check("R4 pulse ends", int'(ack), 0);

        irq_en = 8'hFD; irq_pend = 8'h46;
        gie_set = 1; tick(); gie_set = 0; tick();
        check("R2 mask idx", int'(ack_idx), 2);
        check("R5 nested level", int'(cur_lvl), 2);
        check("R5 nested save", int'(nest_lvls), 8'hC0);
        irq_pend = 8'h42;

        irq_en = 8'hFF;
        gie_set = 1; tick(); gie_set = 0; tick(); tick();
        check("R2 equal waits", int'(ack), 0);
        check("R2 equal level", int'(cur_lvl), 2);

        iret = 1; tick(); iret = 0;
        check("R7 restore", int'(cur_lvl), 6);
        check("R7 bit cleared", int'(nest_lvls), 8'h80);
        tick();
        check("R9 taken next", int'(ack), 1);
        check("R9 idx", int'(ack_idx), 1);
        check("R9 level", int'(cur_lvl), 2);
        irq_pend = 8'h40;

        irq_pend = 8'h50; iret = 1; gie_set = 1; tick(); iret = 0; gie_set = 0;
        check("R8 no ack", int'(ack), 0);
        check("R8 level", int'(cur_lvl), 6);
        check("R8 enable", int'(gie), 1);
        tick();
        check("R8 then take", int'(ack_idx), 4);
        check("R8 then level", int'(cur_lvl), 0);
        irq_pend = 8'h40;

        iret = 1; tick();
        check("R7 second", int'(cur_lvl), 6);
        tick();
        check("R7 last", int'(cur_lvl), 7);
        check("R10 empty", int'(nest_lvls), 0);
        tick();
        check("R7 empty return", int'(cur_lvl), 7);
        iret = 0;
        irq_pend = 8'h46; gie_set = 1; tick(); gie_set = 0; tick();
        check("R3 tie idx", int'(ack_idx), 1);
        check("R3 tie level", int'(cur_lvl), 2);
        irq_pend = 0;

        iret = 1; tick(); iret = 0;
        irq_pend = 8'h89; gie_set = 1; tick(); gie_set = 0; tick();
        check("R3 level wins", int'(ack_idx), 7);
        check("R3 level", int'(cur_lvl), 4);
        irq_pend = 0;

        for (int n = 0; n < 4000; n++) begin
            irq_pend = 8'($urandom);
            irq_en   = 8'($urandom) | 8'h0F;
            gie_set  = ($urandom % 3) == 0;
            iret     = ($urandom % 6) == 0;
            rst      = ($urandom % 500) == 0;
            if (($urandom % 40) == 0) lv[$urandom % 8] = 3'($urandom);
            tick();
        end
        rst = 0; iret = 0; gie_set = 0; irq_pend = 0;
        tick();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule